// File: doc/BRIEF.md
# H-Bridge Fixed Off-Time Current Chopper

This block controls the four gate commands of one H-bridge that drives a single motor winding. While conducting, it turns on the diagonal pair picked by the polarity input. When the external current comparator reports that the winding current has reached its trip level, the block ends the conducting phase. It then holds the bridge in recirculation for a fixed number of clock cycles, after which it starts a new conducting phase without further prompting.

The recirculation period runs in one of two ways. Slow decay shorts the winding through both low-side switches. Mixed decay first reverses the bridge for a fixed fraction of the period: the opposite diagonal pair is switched on for synchronous rectification for (off-time × 5) >> 4 cycles. Slow decay then fills the rest of the period. The comparator is ignored for a blanking window after every phase change and every gate transition. Each leg waits a guard interval with both of its switches off before either one turns on. A fault or a low enable removes all gate drive at the next clock edge, and chopping starts again once the condition clears.

Top module: `hb_chopper`

## Requirements
- R1: Gate order is {high A, low A, high B, low B}. When the polarity sampled at the start of a conducting phase is 0, that phase drives 1001. When it is 1, the phase drives 0110. A polarity change during the phase has no effect until the next conducting phase.
- R2: Once blanking has expired in a conducting phase, a trip input that is high before clock edge k turns the conducting high-side switch off at edge k+1.
- R3: The trip input is ignored for BLANK_CYC cycles after any phase change or gate transition. With trip held high, the conducting high-side switch stays on for exactly BLANK_CYC+2 cycles.
- R4: The recirculation period lasts OFF_CYC cycles. A new conducting phase follows on its own, and the conducting high-side switch is off for exactly OFF_CYC+DEAD_CYC+1 cycles.
- R5: Slow decay drives the pattern 0101, with both low-side switches on and both high-side switches off.
- R6: With mixed decay sampled at the trip, the opposite pair (0110 for polarity 0, 1001 for polarity 1) is driven for (OFF_CYC*5)>>4 cycles. This count is measured from the fall of the conducting high-side switch to the fall of the opposite high-side switch. Slow decay then takes over.
- R7: A switch turns on only after both switches of its leg have been off for at least DEAD_CYC cycles. In slow decay the conducting leg's low side rises exactly DEAD_CYC+1 cycles after its high side falls.
- R8: The high-side and low-side switches of the same leg are never commanded on together.
- R9: A high fault input or a low enable forces all four gates to 0 at the next clock edge. After the condition clears, the conducting pair turns on two clock edges later.
- R10: During and after reset all four gates are 0 until a conducting phase is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trip_i | input | 1 | Current comparator result, high when the trip level is reached |
| mixed_i | input | 1 | Decay select sampled at trip: 1 mixed, 0 slow |
| pol_i | input | 1 | Current direction, sampled at the start of each conducting phase |
| en_i | input | 1 | Enable; low turns all gates off |
| fault_i | input | 1 | Fault; high turns all gates off |
| hs_a_o | output | 1 | High-side gate, leg A |
| ls_a_o | output | 1 | Low-side gate, leg A |
| hs_b_o | output | 1 | High-side gate, leg B |
| ls_b_o | output | 1 | Low-side gate, leg B |

## Verification
The chopping cycle runs with trip held high for all four combinations of polarity and decay mode. Measured edge-to-edge gaps of the gates separate blanking length, off-time length, fast-decay length and dead time, and show which pair each phase drives. Directed sequences cover the remaining cases:
- a trip pulse inside the blanking window, which must not end the phase;
- a trip after blanking, to measure the response latency;
- a polarity change during a conducting phase;
- a fault arriving both in the conducting phase and in the middle of fast decay.

// File: rtl/chop_pkg.sv
package chop_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ON   = 2'd1,
    PH_FAST = 2'd2,
    PH_SLOW = 2'd3
  } phase_e;

  // reversed-bridge share of the off-time: 5/16 of the total
  function automatic int unsigned fast_cycles(input int unsigned off_cyc);
    return (off_cyc * 5) >> 4;
  endfunction

  // gate request {hs_a, ls_a, hs_b, ls_b} for a phase and polarity
  function automatic logic [3:0] gate_req(input phase_e ph, input logic pol);
    logic [3:0] drive_pair;
    logic [3:0] rev_pair;
    drive_pair = pol ? 4'b0110 : 4'b1001;
    rev_pair   = pol ? 4'b1001 : 4'b0110;
    case (ph)
      PH_ON:   return drive_pair;
      PH_FAST: return rev_pair;
      PH_SLOW: return 4'b0101;
      default: return 4'b0000;
    endcase
  endfunction

endpackage

// File: rtl/chop_leg.sv
module chop_leg #(
  parameter int unsigned DEAD_CYC = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_hi,
  input  logic req_lo,
  output logic hi_q,
  output logic lo_q,
  output logic chg
);
  localparam int unsigned DT_W = $clog2(DEAD_CYC + 1);
  localparam logic [DT_W-1:0] DEAD_V = DT_W'(DEAD_CYC);

  logic [DT_W-1:0] gap_cnt;
  logic gap_ok;
  logic hi_d, lo_d;

  assign gap_ok = (gap_cnt == DEAD_V);
  // a switch may stay on, or come on only after the leg has idled long enough
  assign hi_d = req_hi && (hi_q || (!lo_q && gap_ok));
  assign lo_d = req_lo && !req_hi && (lo_q || (!hi_q && gap_ok));
  assign chg  = (hi_d != hi_q) || (lo_d != lo_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q    <= 1'b0;
      lo_q    <= 1'b0;
      gap_cnt <= '0;
    end else begin
      hi_q <= hi_d;
      lo_q <= lo_d;
      if (hi_q || lo_q)      gap_cnt <= '0;
      else if (!gap_ok)      gap_cnt <= gap_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/chop_seq.sv
module chop_seq
  import chop_pkg::*;
#(
  parameter int unsigned OFF_CYC   = 1500,
  parameter int unsigned BLANK_CYC = 50
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   run,
  input  logic   trip,
  input  logic   mixed,
  input  logic   pol,
  input  logic   sw_evt,
  output phase_e phase,
  output logic   pol_q,
  output logic   trip_take,
  output logic   fast_done,
  output logic   off_done
);
  localparam int unsigned OFF_W  = $clog2(OFF_CYC + 1);
  localparam int unsigned BL_W   = $clog2(BLANK_CYC + 1);
  localparam int unsigned FAST_C = fast_cycles(OFF_CYC);
  localparam int unsigned SLOW_C = OFF_CYC - FAST_C;
  localparam logic [OFF_W-1:0] FAST_LD = OFF_W'(FAST_C - 1);
  localparam logic [OFF_W-1:0] SLOW_LD = OFF_W'(SLOW_C - 1);
  localparam logic [OFF_W-1:0] OFF_LD  = OFF_W'(OFF_CYC - 1);
  localparam logic [BL_W-1:0]  BLK_LD  = BL_W'(BLANK_CYC);

  phase_e st, st_nxt;
  logic [OFF_W-1:0] tmr, tmr_nxt;
  logic [BL_W-1:0]  bcnt;
  logic tmr_zero;

  assign tmr_zero  = (tmr == '0);
  assign trip_take = run && (st == PH_ON) && trip && (bcnt == '0);
  assign fast_done = run && (st == PH_FAST) && tmr_zero;
  assign off_done  = run && (st == PH_SLOW) && tmr_zero;
  assign phase     = st;

  always_comb begin
    st_nxt  = st;
    tmr_nxt = tmr;
    if (!run) begin
      st_nxt = PH_IDLE;
    end else begin
      case (st)
        PH_IDLE: st_nxt = PH_ON;
        PH_ON: if (trip_take) begin
          st_nxt  = mixed ? PH_FAST : PH_SLOW;
          tmr_nxt = mixed ? FAST_LD : OFF_LD;
        end
        PH_FAST: if (tmr_zero) begin
          st_nxt  = PH_SLOW;
          tmr_nxt = SLOW_LD;
        end else tmr_nxt = tmr - 1'b1;
        PH_SLOW: if (tmr_zero) st_nxt = PH_ON;
                 else          tmr_nxt = tmr - 1'b1;
        default: st_nxt = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= PH_IDLE;
      tmr   <= '0;
      bcnt  <= BLK_LD;
      pol_q <= 1'b0;
    end else begin
      st  <= st_nxt;
      tmr <= tmr_nxt;
      if ((st_nxt != st) || sw_evt) bcnt <= BLK_LD;
      else if (bcnt != '0)          bcnt <= bcnt - 1'b1;
      if ((st_nxt == PH_ON) && (st != PH_ON)) pol_q <= pol;
    end
  end
endmodule

// File: rtl/hb_chopper.sv
module hb_chopper
  import chop_pkg::*;
#(
  parameter int unsigned OFF_CYC   = 1500,
  parameter int unsigned BLANK_CYC = 50,
  parameter int unsigned DEAD_CYC  = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_i,
  input  logic mixed_i,
  input  logic pol_i,
  input  logic en_i,
  input  logic fault_i,
  output logic hs_a_o,
  output logic ls_a_o,
  output logic hs_b_o,
  output logic ls_b_o
);
  phase_e     phase;
  logic       run, pol_q, sw_evt;
  logic       trip_take, fast_done, off_done, in_fast, in_off;
  logic [3:0] req;
  logic [3:0] gq;
  logic [1:0] leg_chg;

  assign run     = en_i && !fault_i;
  assign req     = run ? gate_req(phase, pol_q) : 4'b0000;
  assign sw_evt  = |leg_chg;
  assign in_fast = (phase == PH_FAST);
  assign in_off  = (phase == PH_FAST) || (phase == PH_SLOW);

  chop_seq #(.OFF_CYC(OFF_CYC), .BLANK_CYC(BLANK_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .run(run), .trip(trip_i), .mixed(mixed_i),
    .pol(pol_i), .sw_evt(sw_evt), .phase(phase), .pol_q(pol_q),
    .trip_take(trip_take), .fast_done(fast_done), .off_done(off_done)
  );

  // leg 1 is A (bits 3:2), leg 0 is B (bits 1:0)
  for (genvar g = 0; g < 2; g++) begin : g_leg
    chop_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
      .clk(clk), .rst_n(rst_n),
      .req_hi(req[2*g+1]), .req_lo(req[2*g]),
      .hi_q(gq[2*g+1]), .lo_q(gq[2*g]), .chg(leg_chg[g])
    );
  end

  assign hs_a_o = gq[3];
  assign ls_a_o = gq[2];
  assign hs_b_o = gq[1];
  assign ls_b_o = gq[0];
endmodule

// File: rtl/hb_chopper_chk.sv
module hb_chopper_chk #(
  parameter int unsigned OFF_CYC   = 1500,
  parameter int unsigned BLANK_CYC = 50,
  parameter int unsigned DEAD_CYC  = 24
) (
  input logic       clk,
  input logic       rst_n,
  input logic       en_i,
  input logic       fault_i,
  input logic       trip_take,
  input logic       fast_done,
  input logic       off_done,
  input logic       in_fast,
  input logic       in_off,
  input logic [1:0] phase,
  input logic [3:0] gates
);
  localparam int FAST_C = int'((OFF_CYC * 5) / 16);

  int fcnt, ocnt, since, quiet, boff_a, boff_b;
  logic [5:0] snap_q;
  logic changed;

  assign changed = ({phase, gates} != snap_q);
  assign quiet   = changed ? 0 : since + 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt <= 0; ocnt <= 0; since <= 0; snap_q <= '0;
      boff_a <= 0; boff_b <= 0;
    end else begin
      fcnt   <= in_fast ? fcnt + 1 : 0;
      ocnt   <= in_off ? ocnt + 1 : 0;
      snap_q <= {phase, gates};
      if (changed) since <= 0;
      else if (since < int'(BLANK_CYC)) since <= since + 1;
      if (gates[3] || gates[2]) boff_a <= 0;
      else if (boff_a <= int'(DEAD_CYC)) boff_a <= boff_a + 1;
      if (gates[1] || gates[0]) boff_b <= 0;
      else if (boff_b <= int'(DEAD_CYC)) boff_b <= boff_b + 1;
    end
  end

  a_r8_leg_a_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(gates[3] && gates[2]));
  a_r8_leg_b_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(gates[1] && gates[0]));
  a_r6_fast_len: assert property (@(posedge clk) disable iff (!rst_n)
    fast_done |-> (fcnt == FAST_C - 1));
  a_r4_off_len: assert property (@(posedge clk) disable iff (!rst_n)
    off_done |-> (ocnt == int'(OFF_CYC) - 1));
  a_r3_blank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    trip_take |-> (quiet >= int'(BLANK_CYC)));
  a_r9_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i || fault_i) |=> (gates == 4'b0000));
  a_r7_dead_a: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gates[3]) || $rose(gates[2])) |-> (boff_a >= int'(DEAD_CYC)));
  a_r7_dead_b: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gates[1]) || $rose(gates[0])) |-> (boff_b >= int'(DEAD_CYC)));
endmodule

bind hb_chopper hb_chopper_chk #(
  .OFF_CYC(OFF_CYC), .BLANK_CYC(BLANK_CYC), .DEAD_CYC(DEAD_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .fault_i(fault_i),
  .trip_take(trip_take), .fast_done(fast_done), .off_done(off_done),
  .in_fast(in_fast), .in_off(in_off), .phase(phase), .gates(gq)
);

// File: tb/hb_chopper_tb.sv
module hb_chopper_tb;
  localparam int OFF = 64;
  localparam int BLK = 8;
  localparam int DT  = 3;
  localparam int FST = (OFF * 5) / 16;

  // {pol, mixed, expected conducting pattern}
  localparam logic [5:0] VECS [4] = '{6'b00_1001, 6'b10_0110, 6'b01_1001, 6'b11_0110};

  logic clk = 1'b0, rst_n = 1'b0;
  logic trip = 0, mixed = 0, pol = 0, en = 0, fault = 0;
  logic hs_a, ls_a, hs_b, ls_b;
  logic [3:0] g;
  int cyc = 0, checks = 0, fails = 0;
  bit done = 0;

  assign g = {hs_a, ls_a, hs_b, ls_b};
  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hb_chopper #(.OFF_CYC(OFF), .BLANK_CYC(BLK), .DEAD_CYC(DT)) u_dut (
    .clk(clk), .rst_n(rst_n), .trip_i(trip), .mixed_i(mixed), .pol_i(pol),
    .en_i(en), .fault_i(fault), .hs_a_o(hs_a), .ls_a_o(ls_a),
    .hs_b_o(hs_b), .ls_b_o(ls_b)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_gate(input int idx, input logic val, input string tag, output int t);
    int n = 0;
    do begin @(negedge clk); n++; end while (g[idx] !== val && n < 3000);
    if (g[idx] !== val) check(0, {tag, " timeout"}, g[idx], val);
    t = cyc;
  endtask

  task automatic idle_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic run_vec(input logic [5:0] v);
    int hi_i, op_i, lo_i, t0, t1, tl, t2, t3, tx;
    logic [3:0] on_p;
    on_p = v[3:0];
    hi_i = v[5] ? 1 : 3;
    op_i = v[5] ? 3 : 1;
    lo_i = v[5] ? 0 : 2;
    pol = v[5]; mixed = v[4]; trip = 0; en = 1;
    wait_gate(hi_i, 1'b1, "R1 start", tx);
    check(g == on_p, "R1 conducting pair", g, on_p);
    trip = 1;
    wait_gate(hi_i, 1'b0, "R2 trip", t0);
    if (v[4]) begin
      idle_n(DT + 2);
      check(g == ~on_p, "R6 reversed pair", g, ~on_p);
      wait_gate(op_i, 1'b0, "R6 fast end", t1);
      check(t1 - t0 == FST, "R6 fast length", t1 - t0, FST);
      idle_n(DT + 2);
      check(g == 4'b0101, "R5 slow after fast", g, 4'b0101);
    end else begin
      wait_gate(lo_i, 1'b1, "R7 low rise", tl);
      check(tl - t0 == DT + 1, "R7 dead gap", tl - t0, DT + 1);
      check(g == 4'b0101, "R5 slow pattern", g, 4'b0101);
    end
    wait_gate(hi_i, 1'b1, "R4 restart", t2);
    check(t2 - t0 == OFF + DT + 1, "R4 off width", t2 - t0, OFF + DT + 1);
    check(g == on_p, "R1 restart pair", g, on_p);
    wait_gate(hi_i, 1'b0, "R3 on end", t3);
    check(t3 - t2 == BLK + 2, "R3 on width", t3 - t2, BLK + 2);
    trip = 0; en = 0;
    idle_n(8);
  endtask

  initial begin
    int t, v;
    idle_n(3);
    check(g == 4'b0000, "R10 in reset", g, 0);
    rst_n = 1;
    idle_n(5);
    check(g == 4'b0000, "R10 after reset, R9 disabled", g, 0);

    for (int i = 0; i < 4; i++) run_vec(VECS[i]);

    // blanking window and trip latency
    pol = 0; mixed = 0; trip = 0; en = 1;
    wait_gate(3, 1'b1, "R3 blank start", t);
    idle_n(2);
    trip = 1; @(negedge clk); trip = 0;
    idle_n(20);
    check(hs_a == 1'b1, "R3 trip in blanking ignored", hs_a, 1);
    trip = 1; v = cyc;
    wait_gate(3, 1'b0, "R2 latency", t);
    check(t - v == 2, "R2 trip latency", t - v, 2);
    trip = 0;

    // fault in conducting phase
    wait_gate(3, 1'b1, "R9 on again", t);
    fault = 1; v = cyc;
    @(negedge clk);
    check(g == 4'b0000 && cyc == v + 1, "R9 fault off", g, 0);
    idle_n(10);
    check(g == 4'b0000, "R9 fault hold", g, 0);
    fault = 0; v = cyc;
    wait_gate(3, 1'b1, "R9 resume", t);
    check(t - v == 2, "R9 resume delay", t - v, 2);
    check(g == 4'b1001, "R1 resume pair", g, 4'b1001);

    // fault during fast decay
    mixed = 1; trip = 1;
    wait_gate(3, 1'b0, "R6 trip", t);
    trip = 0;
    idle_n(DT + 2);
    check(g == 4'b0110, "R6 fast pair", g, 4'b0110);
    fault = 1;
    @(negedge clk);
    check(g == 4'b0000, "R9 fault in fast", g, 0);
    idle_n(5);
    fault = 0; mixed = 0;
    wait_gate(3, 1'b1, "R9 resume2", t);

    // polarity change inside a conducting phase
    pol = 1;
    idle_n(10);
    check(g == 4'b1001, "R1 polarity held", g, 4'b1001);
    trip = 1;
    wait_gate(3, 1'b0, "R1 trip", t);
    trip = 0;
    wait_gate(1, 1'b1, "R1 new polarity", t);
    check(g == 4'b0110, "R1 new polarity pair", g, 4'b0110);
    en = 0;
    @(negedge clk);
    check(g == 4'b0000, "R9 enable low", g, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule